// File: doc/BRIEF.md
# Indirect PHY Register Access Sequencer

This block lets a host reach a numbered PHY management register that is only visible through a 16-bit switch register bus. The host gives a PHY number, a register number, a direction flag and, for writes, a data word. The block turns that into a fixed series of switch bus transactions. The first transaction programs an access-control register with the direction. The second transaction targets a synthesized window address, where the PHY number is a one-hot bit and the register number sits in the low bits. A read adds a third transaction that fetches the result from an access-data register.

When the sequence is over, the block raises `done` for one cycle, with `err` and `rdata` describing the outcome. A PHY number outside the supported range is refused before any bus traffic. A bus error on any step ends the sequence at once. The bus side uses a simple hold-until-ready handshake.

Top module: `phy_indirect_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `bus_valid`, `done` and `err` are 0 and `rdata` is 0.
- R2: The first transaction of every accepted request is a write (`bus_write`=1) to address 0x8028, with data 1 for a PHY read and 0 for a PHY write.
- R3: The second transaction is a write to address 0x8000 with bit (9 + PHY number) set and the 5-bit register number in bits 4:0. No other bits are set.
- R4: For a PHY write, the second transaction carries `req_wdata`. It is the last transaction. `done` is high, with `err`=0, in the cycle after its handshake.
- R5: For a PHY read, the second transaction carries data 0. A third transaction reads (`bus_write`=0) address 0x8029. Its `bus_rdata` appears on `rdata` together with a one-cycle `done`, with `err`=0, in the cycle after that handshake.
- R6: A request whose PHY number exceeds 4 raises `done` and `err` in the next cycle. It issues no bus transaction.
- R7: A handshake with `bus_err`=1 on any step ends the sequence. The next cycle has `done`=1, `err`=1 and `bus_valid`=0, and no further transaction of that request follows.
- R8: A request is taken only while `busy` is 0. A `req_valid` pulse during a sequence has no effect on the addresses, the data or the outcome of that sequence.
- R9: `rdata` and `err` hold their values until the next accepted request, which clears both to 0.
- R10: While `bus_valid` is 1 and `bus_ready` is 0, `bus_valid`, `bus_write`, `bus_addr` and `bus_wdata` stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = PHY write, 0 = PHY read |
| req_phy | input | 3 | PHY number |
| req_reg | input | 5 | PHY register number |
| req_wdata | input | 16 | Data for a PHY write |
| busy | output | 1 | A bus sequence is in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Outcome of the last request was an error |
| rdata | output | 16 | Result of the last successful PHY read |
| bus_valid | output | 1 | Switch bus transaction pending |
| bus_write | output | 1 | 1 = bus write, 0 = bus read |
| bus_addr | output | 16 | Switch register address |
| bus_wdata | output | 16 | Switch register write data |
| bus_ready | input | 1 | Transaction completes this cycle |
| bus_err | input | 1 | Transaction failed, sampled with ready |
| bus_rdata | input | 16 | Switch register read data, sampled with ready |

## Verification
Each bus transaction appears on the bus side in the cycle right after the request is accepted or the previous handshake completes. `done`, `err` and `rdata` appear in the cycle after the final handshake, or in the cycle after acceptance for a refused PHY number. The bench keeps a behavioural model that steps on each rising edge from the same inputs. It compares every output at the falling edge, so each result is checked in exactly the cycle it is due. Responder latencies of zero to three wait cycles and error injection on each step move these cycles around. The model follows them without any fixed delay being assumed.

// File: rtl/physeq_pkg.sv
package physeq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CTRL = 2'd1,
      ST_WIN  = 2'd2,
      ST_RDAT = 2'd3
   } seq_step_e;

endpackage

// File: rtl/physeq_addr_gen.sv
module physeq_addr_gen #(
   parameter int ADDR_W    = 16,
   parameter int PHY_W     = 3,
   parameter int PHY_MAX   = 4,
   parameter int REG_W     = 5,
   parameter int PHY_SHIFT = 9,
   parameter logic [ADDR_W-1:0] WIN_BASE = 16'h8000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [PHY_W-1:0]  phy_num,
   input  logic [REG_W-1:0]  reg_num,
   output logic              phy_ok,
   output logic [ADDR_W-1:0] win_addr
);
   localparam int N_PHY = PHY_MAX + 1;

   logic [N_PHY-1:0]  phy_sel;
   logic [ADDR_W-1:0] sel_field;
   logic [ADDR_W-1:0] reg_field;

   for (genvar i = 0; i < N_PHY; i++) begin : g_sel
      assign phy_sel[i] = (phy_num == PHY_W'(i));
   end

   assign phy_ok    = |phy_sel;
   assign sel_field = ADDR_W'(phy_sel) << PHY_SHIFT;
   assign reg_field = ADDR_W'(reg_num);
   assign win_addr  = WIN_BASE | sel_field | reg_field;

   // Exactly one PHY select bit in the window field, register in low bits
   assert_onehot_select_R3: assert property (@(posedge clk) disable iff (rst)
      phy_ok |-> ($countones(win_addr[PHY_SHIFT +: N_PHY]) == 1) &&
                 (win_addr[REG_W-1:0] == reg_num));

endmodule

// File: rtl/physeq_bus_mux.sv
module physeq_bus_mux
   import physeq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h8028,
   parameter logic [ADDR_W-1:0] DATA_ADDR = 16'h8029
) (
   input  seq_step_e         step,
   input  logic              is_write,
   input  logic [ADDR_W-1:0] win_addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              bus_valid,
   output logic              bus_write,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata
);
   always_comb begin
      bus_valid = 1'b0;
      bus_write = 1'b0;
      bus_addr  = '0;
      bus_wdata = '0;
      unique case (step)
         ST_CTRL: begin
            bus_valid = 1'b1;
            bus_write = 1'b1;
            bus_addr  = CTRL_ADDR;
            bus_wdata = DATA_W'(!is_write);
         end
         ST_WIN: begin
            bus_valid = 1'b1;
            bus_write = 1'b1;
            bus_addr  = win_addr;
            bus_wdata = is_write ? wdata : '0;
         end
         ST_RDAT: begin
            bus_valid = 1'b1;
            bus_write = 1'b0;
            bus_addr  = DATA_ADDR;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/physeq_ctrl.sv
module physeq_ctrl
   import physeq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              phy_ok,
   input  logic [ADDR_W-1:0] req_win_addr,
   input  logic              bus_valid,
   input  logic              bus_ready,
   input  logic              bus_err,
   input  logic [DATA_W-1:0] bus_rdata,
   output seq_step_e         step,
   output logic              lat_write,
   output logic [ADDR_W-1:0] lat_win_addr,
   output logic [DATA_W-1:0] lat_wdata,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [DATA_W-1:0] rdata
);
   logic accept;
   logic hs;

   assign busy   = (step != ST_IDLE);
   assign accept = req_valid && !busy;
   assign hs     = bus_valid && bus_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         step         <= ST_IDLE;
         lat_write    <= 1'b0;
         lat_win_addr <= '0;
         lat_wdata    <= '0;
         done         <= 1'b0;
         err          <= 1'b0;
         rdata        <= '0;
      end else begin
         done <= 1'b0;
         unique case (step)
            ST_IDLE: begin
               if (accept) begin
                  err   <= 1'b0;
                  rdata <= '0;
                  if (phy_ok) begin
                     step         <= ST_CTRL;
                     lat_write    <= req_write;
                     lat_win_addr <= req_win_addr;
                     lat_wdata    <= req_wdata;
                  end else begin
                     done <= 1'b1;
                     err  <= 1'b1;
                  end
               end
            end
            ST_CTRL: begin
               if (hs) begin
                  if (bus_err) begin
                     step <= ST_IDLE;
                     done <= 1'b1;
                     err  <= 1'b1;
                  end else begin
                     step <= ST_WIN;
                  end
               end
            end
            ST_WIN: begin
               if (hs) begin
                  if (bus_err) begin
                     step <= ST_IDLE;
                     done <= 1'b1;
                     err  <= 1'b1;
                  end else if (lat_write) begin
                     step <= ST_IDLE;
                     done <= 1'b1;
                  end else begin
                     step <= ST_RDAT;
                  end
               end
            end
            ST_RDAT: begin
               if (hs) begin
                  step <= ST_IDLE;
                  done <= 1'b1;
                  if (bus_err) err <= 1'b1;
                  else         rdata <= bus_rdata;
               end
            end
            default: step <= ST_IDLE;
         endcase
      end
   end

   // Refused PHY number: done with error next cycle, bus untouched
   assert_bad_phy_no_bus_R6: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !busy && !phy_ok) |=> (done && err && !bus_valid));

   // Bus error ends the sequence immediately
   assert_abort_on_error_R7: assert property (@(posedge clk) disable iff (rst)
      (bus_valid && bus_ready && bus_err) |=> (done && err && !bus_valid));

   // A new sequence starts with no stale result
   assert_clear_on_start_R9: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !busy && phy_ok) |=> (!err && rdata == '0 && busy));

endmodule

// File: rtl/phy_indirect_seq.sv
module phy_indirect_seq
   import physeq_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 16,
   parameter int PHY_W     = 3,
   parameter int PHY_MAX   = 4,
   parameter int REG_W     = 5,
   parameter int PHY_SHIFT = 9,
   parameter logic [ADDR_W-1:0] WIN_BASE  = 16'h8000,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h8028,
   parameter logic [ADDR_W-1:0] DATA_ADDR = 16'h8029
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [PHY_W-1:0]  req_phy,
   input  logic [REG_W-1:0]  req_reg,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [DATA_W-1:0] rdata,
   output logic              bus_valid,
   output logic              bus_write,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_ready,
   input  logic              bus_err,
   input  logic [DATA_W-1:0] bus_rdata
);
   localparam int TOP_SEL_BIT = PHY_SHIFT + PHY_MAX;

   if (TOP_SEL_BIT >= ADDR_W) begin : g_chk_width
      $error("PHY select field does not fit in the address");
   end
   if (PHY_SHIFT < REG_W) begin : g_chk_overlap
      $error("PHY select field overlaps the register field");
   end
   if (PHY_MAX >= (1 << PHY_W)) begin : g_chk_phy
      $error("PHY_W too narrow for PHY_MAX");
   end

   seq_step_e         step;
   logic              phy_ok;
   logic [ADDR_W-1:0] req_win_addr;
   logic              lat_write;
   logic [ADDR_W-1:0] lat_win_addr;
   logic [DATA_W-1:0] lat_wdata;

   physeq_addr_gen #(
      .ADDR_W(ADDR_W), .PHY_W(PHY_W), .PHY_MAX(PHY_MAX),
      .REG_W(REG_W), .PHY_SHIFT(PHY_SHIFT), .WIN_BASE(WIN_BASE)
   ) u_addr (
      .clk(clk), .rst(rst),
      .phy_num(req_phy), .reg_num(req_reg),
      .phy_ok(phy_ok), .win_addr(req_win_addr)
   );

   physeq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst(rst),
      .req_valid(req_valid), .req_write(req_write), .req_wdata(req_wdata),
      .phy_ok(phy_ok), .req_win_addr(req_win_addr),
      .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_err(bus_err),
      .bus_rdata(bus_rdata),
      .step(step), .lat_write(lat_write), .lat_win_addr(lat_win_addr),
      .lat_wdata(lat_wdata),
      .busy(busy), .done(done), .err(err), .rdata(rdata)
   );

   physeq_bus_mux #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)
   ) u_mux (
      .step(step), .is_write(lat_write), .win_addr(lat_win_addr),
      .wdata(lat_wdata),
      .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata)
   );

   // Bus request held steady until completed
   assert_hold_until_ready_R10: assert property (@(posedge clk) disable iff (rst)
      (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) &&
                                     $stable(bus_wdata) && $stable(bus_write)));

   // Every sequence opens with the access-control write
   assert_first_is_ctrl_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(bus_valid) |-> (bus_addr == CTRL_ADDR && bus_write));

   // A write access finishes after its window transaction
   assert_write_ends_after_window_R4: assert property (@(posedge clk) disable iff (rst)
      (bus_valid && bus_ready && !bus_err && bus_write && bus_addr != CTRL_ADDR)
      |=> (done && !err && !bus_valid) || (bus_valid && !bus_write));

endmodule

// File: tb/phy_indirect_seq_test.sv
module phy_indirect_seq_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [2:0]  req_phy = '0;
   logic [4:0]  req_reg = '0;
   logic [15:0] req_wdata = '0;
   logic        busy, done, err;
   logic [15:0] rdata;
   logic        bus_valid, bus_write;
   logic [15:0] bus_addr, bus_wdata;
   logic        bus_ready = 1'b0;
   logic        bus_err = 1'b0;
   logic [15:0] bus_rdata = '0;

   phy_indirect_seq uut (
      .clk(clk), .rst(rst),
      .req_valid(req_valid), .req_write(req_write), .req_phy(req_phy),
      .req_reg(req_reg), .req_wdata(req_wdata),
      .busy(busy), .done(done), .err(err), .rdata(rdata),
      .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_ready(bus_ready), .bus_err(bus_err), .bus_rdata(bus_rdata)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int    vectors = 0;
   int    miscompares = 0;
   string tag = "R1";
   bit    started = 1'b0;
   bit    finished = 1'b0;

   // responder settings
   int          lat = 0;
   int          wait_cnt = 0;
   logic [15:0] err_addr = 16'h0000;
   logic [15:0] rd_val = 16'h0000;

   // behavioural model
   int          m_step = 0;
   bit          m_write = 0;
   int          m_phy = 0;
   int          m_reg = 0;
   logic [15:0] m_wdata = 0;
   bit          m_done = 0;
   bit          m_err = 0;
   logic [15:0] m_rdata = 0;

   always @(posedge clk) begin
      if (rst) begin
         m_step = 0; m_done = 0; m_err = 0; m_rdata = 0;
      end else begin
         started = 1'b1;
         m_done = 0;
         case (m_step)
            0: if (req_valid) begin
               m_err = 0; m_rdata = 0;
               if (req_phy > 4) begin
                  m_done = 1; m_err = 1;
               end else begin
                  m_step = 1; m_write = req_write; m_phy = req_phy;
                  m_reg = req_reg; m_wdata = req_wdata;
               end
            end
            1: if (bus_ready) begin
               if (bus_err) begin m_step = 0; m_done = 1; m_err = 1; end
               else m_step = 2;
            end
            2: if (bus_ready) begin
               if (bus_err) begin m_step = 0; m_done = 1; m_err = 1; end
               else if (m_write) begin m_step = 0; m_done = 1; end
               else m_step = 3;
            end
            default: if (bus_ready) begin
               m_step = 0; m_done = 1;
               if (bus_err) m_err = 1;
               else m_rdata = bus_rdata;
            end
         endcase
      end
   end

   task automatic chk(string name, logic [31:0] act, logic [31:0] exp);
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", tag, name, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (started && !rst) begin
         logic [15:0] e_addr, e_wd;
         bit e_wr;
         e_addr = 16'h0; e_wd = 16'h0; e_wr = 1'b1;
         case (m_step)
            1: begin e_addr = 16'h8028; e_wd = m_write ? 16'h0 : 16'h1; end
            2: begin
               e_addr = 16'h8000 | (16'h1 << (m_phy + 9)) | 16'(m_reg);
               e_wd = m_write ? m_wdata : 16'h0;
            end
            3: begin e_addr = 16'h8029; e_wr = 1'b0; end
            default: ;
         endcase
         vectors++;
         chk("busy", 32'(busy), 32'(m_step != 0));
         chk("bus_valid", 32'(bus_valid), 32'(m_step != 0));
         chk("done", 32'(done), 32'(m_done));
         chk("err", 32'(err), 32'(m_err));
         chk("rdata", 32'(rdata), 32'(m_rdata));
         if (m_step != 0) begin
            chk("bus_addr", 32'(bus_addr), 32'(e_addr));
            chk("bus_wdata", 32'(bus_wdata), 32'(e_wd));
            chk("bus_write", 32'(bus_write), 32'(e_wr));
         end
      end
   end

   // bus responder
   always @(negedge clk) begin
      if (rst || !bus_valid || bus_ready) begin
         bus_ready = 1'b0; bus_err = 1'b0; wait_cnt = 0;
      end else if (wait_cnt >= lat) begin
         bus_ready = 1'b1;
         bus_err   = (bus_addr == err_addr);
         bus_rdata = rd_val;
      end else begin
         wait_cnt++;
      end
   end

   task automatic request(input bit wr, input int phy, input int rg, input logic [15:0] wd);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_phy = 3'(phy);
      req_reg = 5'(rg); req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic settle();
      repeat (20) @(negedge clk);
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      tag = "R1";
      repeat (3) @(negedge clk);
      rst = 1'b0;
      repeat (3) @(negedge clk);

      tag = "R4"; lat = 0;
      request(1'b1, 0, 0, 16'hA5C3);
      settle();
      tag = "R2";
      request(1'b1, 3, 7, 16'h1234);
      settle();

      tag = "R5"; lat = 2; rd_val = 16'hBEEF;
      request(1'b0, 4, 31, 16'hFFFF);
      settle();

      tag = "R10"; lat = 3;
      request(1'b1, 2, 21, 16'h0F0F);
      settle();

      tag = "R3"; lat = 1; rd_val = 16'h7E01;
      for (int p = 0; p <= 4; p++) begin
         request(p[0], p, 5 * p + 1, 16'(p * 16'h1111));
         settle();
      end

      tag = "R6";
      request(1'b0, 5, 3, 16'h0);
      settle();
      request(1'b1, 7, 9, 16'h55AA);
      settle();

      tag = "R7"; lat = 1;
      err_addr = 16'h8028;
      request(1'b0, 1, 2, 16'h0);
      settle();
      err_addr = 16'h8000 | (16'h1 << 12) | 16'd4;
      request(1'b1, 3, 4, 16'hCAFE);
      settle();
      err_addr = 16'h8029; rd_val = 16'h9999;
      request(1'b0, 0, 6, 16'h0);
      settle();
      err_addr = 16'h0000;

      tag = "R8"; lat = 3; rd_val = 16'h3C3C;
      request(1'b0, 2, 10, 16'h0);
      request(1'b1, 0, 0, 16'hDEAD);
      request(1'b1, 6, 1, 16'hDEAD);
      settle();

      tag = "R9"; lat = 0; rd_val = 16'h4242;
      request(1'b0, 1, 17, 16'h0);
      repeat (40) @(negedge clk);
      request(1'b1, 1, 17, 16'h1111);
      settle();
      request(1'b1, 6, 0, 16'h0);
      repeat (10) @(negedge clk);
      request(1'b1, 0, 1, 16'h2222);
      settle();

      report();
   end
endmodule